// File: doc/BRIEF.md
# Transfer Descriptor Integrity Checker

This block inspects a sixteen-word transfer descriptor, 32 bits per word, while the words arrive one per cycle. A fetch engine presents each word with a strobe and its word index. When the final word arrives in order, the block issues a verdict: either the descriptor is good, or it carries one ranked error code. The block also gives a decoded channel status word built from the control fields and the timestamp done flag. When the descriptor requests it, the block gives the timestamp word with its done flag forced on, ready for the engine to write back to memory.

Word 0 holds the control fields and word 5 holds the timestamp, whose top bit is the done flag. Word 15 carries an optional additive checksum. The block reads no memory. It only watches the word stream and tells the surrounding engine whether the descriptor may be used.

Top module: `dscr_guard`

## Requirements
- R1: After reset, chk_done, chk_pass, err_code, proto_err, status_word, wb_req and wb_word are all zero.
- R2: A completed descriptor whose control word (word 0) has bits 7:0 other than 0xA5 fails with err_code 1.
- R3: When control bit 20 is set, the descriptor fails with err_code 2 unless word 15 equals the modulo-2^32 sum of words 0 to 14. When bit 20 is clear, the value of word 15 has no effect on the verdict.
- R4: When bit 31 of word 5 is set and control bit 10 is clear, the descriptor fails with err_code 3. When control bit 10 is set, the done flag causes no error.
- R5: Only one error code is reported. The preamble check (1) outranks the checksum check (2), which outranks the done-flag check (3). A passing descriptor reports chk_pass=1 and err_code 0.
- R6: chk_done is high for exactly the one cycle after the clock edge that accepts word 15 in sequence. chk_pass, err_code, status_word, wb_req and wb_word keep their values until the next accepted index-0 word, which sets them to zero.
- R7: status_word holds control bits 7:0 at bits 20:13. It also copies control bit 11 to bit 4, bit 18 to 5, bit 20 to 6, bit 19 to 7, bit 21 to 8, bit 10 to 9, word-5 bit 31 to 10, control bit 9 to 11 and control bit 8 to 12. All other bits are zero.
- R8: wb_req is 1 together with the verdict only when the descriptor passes and control bit 9 is set. wb_word is word 5 with bit 31 forced to 1.
- R9: A word with an index of 0 always starts a new descriptor and restarts the checksum. A word with a nonzero index other than the next expected one sets proto_err. proto_err then stays set until the next index-0 word, and that descriptor produces no chk_done.
- R10: Idle cycles (word_vld low) between words do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_vld | input | 1 | Descriptor word strobe |
| word_idx | input | 4 | Index of the presented word |
| word_data | input | 32 | Descriptor word |
| chk_done | output | 1 | One-cycle verdict pulse |
| chk_pass | output | 1 | Descriptor passed all checks |
| err_code | output | 2 | 0 none, 1 preamble, 2 checksum, 3 already done |
| proto_err | output | 1 | Word sequence broken |
| status_word | output | 32 | Decoded channel status |
| wb_req | output | 1 | Write-back of the done-flag word requested |
| wb_word | output | 32 | Timestamp word with the done flag set |

## Verification
The bench builds the block with its default parameters: sixteen words of 32 bits. At that size the real layout is used, so the checksum compare falls on word 15 and the done flag sits at word 5 bit 31. With these values the bench can cover checksum wraparound with large word values, descriptors that are interrupted by a fresh index-0 word, and a sequence that skips one index. Each error is triggered both alone and together with the lower-ranked errors.

// File: rtl/dscr_chk_pkg.sv
// Shared constants and types for the descriptor integrity checker.
// Assumes descriptor words of at least 32 bits.
package dscr_chk_pkg;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_PREAMBLE = 2'd1,
        ERR_SUM      = 2'd2,
        ERR_REDONE   = 2'd3
    } dscr_err_e;

    localparam logic [7:0] PREAMBLE_KEY = 8'hA5;

    // control word field positions
    localparam int CTL_IRQ_EN    = 8;
    localparam int CTL_UPD_EN    = 9;
    localparam int CTL_IGN_DONE  = 10;
    localparam int CTL_BURST     = 11;
    localparam int CTL_MODE      = 18;
    localparam int CTL_LAST      = 19;
    localparam int CTL_SUM_EN    = 20;
    localparam int CTL_LAST_FRM  = 21;

    // timestamp word done flag
    localparam int STAMP_DONE    = 31;

    // decoded status word positions
    localparam int ST_BURST      = 4;
    localparam int ST_MODE       = 5;
    localparam int ST_SUM_EN     = 6;
    localparam int ST_LAST       = 7;
    localparam int ST_LAST_FRM   = 8;
    localparam int ST_IGN_DONE   = 9;
    localparam int ST_DONE       = 10;
    localparam int ST_UPD_EN     = 11;
    localparam int ST_IRQ_EN     = 12;
    localparam int ST_KEY_LSB    = 13;

endpackage

// File: rtl/dscr_seq_track.sv
// Tracks the word index stream of one descriptor.
// An index-0 word always starts a new descriptor. Any other word must
// carry the next expected index, or the sequence is marked broken until
// the next index-0 word. Assumes NUM_WORDS >= 2.
module dscr_seq_track #(
    parameter int NUM_WORDS = 16,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_vld,
    input  logic [IDX_W-1:0] word_idx,
    output logic             start,
    output logic             accept,
    output logic             final_word,
    output logic             broken
);
    localparam logic [IDX_W-1:0] LAST_I = IDX_W'(NUM_WORDS - 1);

    logic [IDX_W-1:0] exp_q;
    logic             broken_q;
    logic             in_order;

    // classify the presented word
    always_comb begin
        start      = word_vld && (word_idx == '0);
        in_order   = word_vld && !start && !broken_q && (word_idx == exp_q);
        accept     = start || in_order;
        final_word = in_order && (word_idx == LAST_I);
    end

    // advance the expected index and flag ordering faults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q    <= '0;
            broken_q <= 1'b0;
        end else if (start) begin
            exp_q    <= IDX_W'(1);
            broken_q <= 1'b0;
        end else if (in_order) begin
            exp_q    <= exp_q + 1'b1;
        end else if (word_vld) begin
            broken_q <= 1'b1;
        end
    end

    assign broken = broken_q;
endmodule

// File: rtl/dscr_sum_acc.sv
// Running 32-bit wraparound sum of the descriptor words that precede the
// checksum word. The sum restarts with the index-0 word and is compared
// with the presented word. Assumes the compare is used only on the final word.
module dscr_sum_acc #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16,
    parameter int IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              accept,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [DATA_W-1:0] word_data,
    output logic              sum_ok
);
    localparam logic [IDX_W-1:0] LAST_I = IDX_W'(NUM_WORDS - 1);

    logic [DATA_W-1:0] sum_q;

    // accumulate the words before the checksum word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (start) begin
            sum_q <= word_data;
        end else if (accept && (word_idx != LAST_I)) begin
            sum_q <= sum_q + word_data;
        end
    end

    // compare the running sum with the presented word
    always_comb sum_ok = (sum_q == word_data);
endmodule

// File: rtl/dscr_field_cap.sv
// Captures the descriptor words that the verdict needs later: the control
// word and the timestamp word. Only in-sequence words are captured.
module dscr_field_cap #(
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 4,
    parameter int CTRL_POS  = 0,
    parameter int STAMP_POS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [DATA_W-1:0] word_data,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] stamp_word
);
    localparam int CAP_N = 2;

    logic [CAP_N-1:0][DATA_W-1:0] cap_d;

    for (genvar k = 0; k < CAP_N; k++) begin : g_slot
        localparam logic [IDX_W-1:0] POS = IDX_W'((k == 0) ? CTRL_POS : STAMP_POS);
        logic [DATA_W-1:0] slot_q;

        // hold the word seen at this slot's index
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (accept && (word_idx == POS)) begin
                slot_q <= word_data;
            end
        end

        assign cap_d[k] = slot_q;
    end

    assign ctrl_word  = cap_d[0];
    assign stamp_word = cap_d[1];
endmodule

// File: rtl/dscr_verdict.sv
// Ranks the descriptor checks, decodes the status word and registers the
// result on the final word. The result is cleared when a new descriptor
// starts. Assumes DATA_W >= 32.
module dscr_verdict
    import dscr_chk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              final_word,
    input  logic              sum_ok,
    input  logic [DATA_W-1:0] ctrl_word,
    input  logic [DATA_W-1:0] stamp_word,
    output logic              done_o,
    output logic              pass_o,
    output logic [1:0]        err_o,
    output logic [DATA_W-1:0] status_o,
    output logic              wb_req_o,
    output logic [DATA_W-1:0] wb_word_o
);
    dscr_err_e         err_nx;
    logic [DATA_W-1:0] status_nx;
    logic [DATA_W-1:0] wb_nx;
    logic              pre_bad, sum_bad, redone;

    logic              done_q, pass_q, wb_req_q;
    dscr_err_e         err_q;
    logic [DATA_W-1:0] status_q, wb_word_q;

    // evaluate the checks in rank order
    always_comb begin
        pre_bad = (ctrl_word[7:0] != PREAMBLE_KEY);
        sum_bad = ctrl_word[CTL_SUM_EN] && !sum_ok;
        redone  = stamp_word[STAMP_DONE] && !ctrl_word[CTL_IGN_DONE];
        if (pre_bad)      err_nx = ERR_PREAMBLE;
        else if (sum_bad) err_nx = ERR_SUM;
        else if (redone)  err_nx = ERR_REDONE;
        else              err_nx = ERR_NONE;
    end

    // decode the channel status word
    always_comb begin
        status_nx                       = '0;
        status_nx[ST_KEY_LSB +: 8]      = ctrl_word[7:0];
        status_nx[ST_BURST]             = ctrl_word[CTL_BURST];
        status_nx[ST_MODE]              = ctrl_word[CTL_MODE];
        status_nx[ST_SUM_EN]            = ctrl_word[CTL_SUM_EN];
        status_nx[ST_LAST]              = ctrl_word[CTL_LAST];
        status_nx[ST_LAST_FRM]          = ctrl_word[CTL_LAST_FRM];
        status_nx[ST_IGN_DONE]          = ctrl_word[CTL_IGN_DONE];
        status_nx[ST_DONE]              = stamp_word[STAMP_DONE];
        status_nx[ST_UPD_EN]            = ctrl_word[CTL_UPD_EN];
        status_nx[ST_IRQ_EN]            = ctrl_word[CTL_IRQ_EN];
    end

    // form the write-back timestamp word
    always_comb begin
        wb_nx             = stamp_word;
        wb_nx[STAMP_DONE] = 1'b1;
    end

    // register the verdict and clear it on a new descriptor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            pass_q    <= 1'b0;
            err_q     <= ERR_NONE;
            status_q  <= '0;
            wb_req_q  <= 1'b0;
            wb_word_q <= '0;
        end else begin
            done_q <= final_word;
            if (start) begin
                pass_q    <= 1'b0;
                err_q     <= ERR_NONE;
                status_q  <= '0;
                wb_req_q  <= 1'b0;
                wb_word_q <= '0;
            end else if (final_word) begin
                pass_q    <= (err_nx == ERR_NONE);
                err_q     <= err_nx;
                status_q  <= status_nx;
                wb_req_q  <= (err_nx == ERR_NONE) && ctrl_word[CTL_UPD_EN];
                wb_word_q <= wb_nx;
            end
        end
    end

    assign done_o    = done_q;
    assign pass_o    = pass_q;
    assign err_o     = err_q;
    assign status_o  = status_q;
    assign wb_req_o  = wb_req_q;
    assign wb_word_o = wb_word_q;
endmodule

// File: rtl/dscr_guard.sv
// Top of the descriptor integrity checker. It watches a descriptor
// arriving one word per cycle and reports a ranked verdict, a decoded
// status word and the done-flag write-back word one cycle after the
// final word. Assumes the fetch engine presents each word only once.
module dscr_guard #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16,
    parameter int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [DATA_W-1:0] word_data,
    output logic              chk_done,
    output logic              chk_pass,
    output logic [1:0]        err_code,
    output logic              proto_err,
    output logic [DATA_W-1:0] status_word,
    output logic              wb_req,
    output logic [DATA_W-1:0] wb_word
);
    logic              start, accept, final_word, sum_ok;
    logic [DATA_W-1:0] ctrl_word, stamp_word;

    dscr_seq_track #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_idx(word_idx),
        .start(start), .accept(accept), .final_word(final_word),
        .broken(proto_err)
    );

    dscr_sum_acc #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
        .word_idx(word_idx), .word_data(word_data), .sum_ok(sum_ok)
    );

    dscr_field_cap #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CTRL_POS(0), .STAMP_POS(5)) u_cap (
        .clk(clk), .rst_n(rst_n), .accept(accept), .word_idx(word_idx),
        .word_data(word_data), .ctrl_word(ctrl_word), .stamp_word(stamp_word)
    );

    dscr_verdict #(.DATA_W(DATA_W)) u_verdict (
        .clk(clk), .rst_n(rst_n), .start(start), .final_word(final_word),
        .sum_ok(sum_ok), .ctrl_word(ctrl_word), .stamp_word(stamp_word),
        .done_o(chk_done), .pass_o(chk_pass), .err_o(err_code),
        .status_o(status_word), .wb_req_o(wb_req), .wb_word_o(wb_word)
    );
endmodule

// File: rtl/dscr_guard_chk.sv
// Property checker for dscr_guard, bound to every instance of the top.
module dscr_guard_chk #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 16,
    parameter int IDX_W     = $clog2(NUM_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_vld,
    input logic [IDX_W-1:0]  word_idx,
    input logic              chk_done,
    input logic              chk_pass,
    input logic [1:0]        err_code,
    input logic              proto_err,
    input logic [DATA_W-1:0] status_word,
    input logic              wb_req,
    input logic [DATA_W-1:0] wb_word
);
    localparam logic [IDX_W-1:0] LAST_I = IDX_W'(NUM_WORDS - 1);

    // R6: verdict strobe lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |=> !chk_done);

    // R6: verdict follows an accepted final word
    a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> $past(word_vld && (word_idx == LAST_I)));

    // R5: pass flag and error code agree
    a_r5_pass_code: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> (chk_pass == (err_code == 2'd0)));

    // R7: a passing descriptor shows the preamble in the status word
    a_r7_key_field: assert property (@(posedge clk) disable iff (!rst_n)
        chk_pass |-> (status_word[20:13] == 8'hA5));

    // R8: write-back only for a passing descriptor, with the done flag set
    a_r8_wb_pass: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (chk_pass && wb_word[31]));

    // R9: an index-0 word clears the ordering flag and the verdict
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && (word_idx == '0)) |=> (!proto_err && !chk_pass && !chk_done));

    // R9: the ordering flag moves only on a presented word
    a_r9_flag_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(proto_err));

    // R9: a broken sequence yields no verdict
    a_r9_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> !chk_done);
endmodule

bind dscr_guard dscr_guard_chk #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
) u_dscr_guard_chk (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_idx(word_idx),
    .chk_done(chk_done), .chk_pass(chk_pass), .err_code(err_code),
    .proto_err(proto_err), .status_word(status_word), .wb_req(wb_req),
    .wb_word(wb_word)
);

// File: tb/tb_dscr_guard.sv
`timescale 1ns/1ps
module tb_dscr_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic [3:0]  word_idx = '0;
    logic [31:0] word_data = '0;
    logic        chk_done, chk_pass, proto_err, wb_req;
    logic [1:0]  err_code;
    logic [31:0] status_word, wb_word;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] dw [16];

    always #10 clk = ~clk;

    dscr_guard dut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_idx(word_idx),
        .word_data(word_data), .chk_done(chk_done), .chk_pass(chk_pass),
        .err_code(err_code), .proto_err(proto_err), .status_word(status_word),
        .wb_req(wb_req), .wb_word(wb_word)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(input logic [31:0] c, input logic [31:0] s);
        logic [31:0] r = '0;
        r[20:13] = c[7:0];
        r[4] = c[11]; r[5] = c[18]; r[6] = c[20]; r[7] = c[19];
        r[8] = c[21]; r[9] = c[10]; r[10] = s[31]; r[11] = c[9]; r[12] = c[8];
        return r;
    endfunction

    // build a descriptor; optionally place the correct sum in word 15
    task automatic fill(input logic [31:0] ctrl, input logic [31:0] stamp, input bit fix_sum);
        logic [31:0] s = '0;
        for (int i = 0; i < 16; i++) dw[i] = 32'hF000_0000 + 32'h0111_1111 * i + 32'h37;
        dw[0] = ctrl;
        dw[5] = stamp;
        for (int i = 0; i < 15; i++) s = s + dw[i];
        dw[15] = fix_sum ? s : s + 32'd1;
    endtask

    task automatic put_word(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        word_vld  = 1'b1;
        word_idx  = idx;
        word_data = d;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        word_vld = 1'b0;
    endtask

    // send all words; leaves the bench at the negedge after word 15
    task automatic send_all(input int gap);
        for (int i = 0; i < 16; i++) begin
            put_word(4'(i), dw[i]);
            for (int g = 0; g < gap; g++) idle();
        end
        if (gap == 0) idle();
    endtask

    task automatic expect_verdict(input string req, input logic pass,
                                  input logic [1:0] code, input logic wbq);
        check_eq(req, "chk_done", 32'(chk_done), 32'd1);
        check_eq(req, "chk_pass", 32'(chk_pass), 32'(pass));
        check_eq(req, "err_code", 32'(err_code), 32'(code));
        check_eq(req, "wb_req", 32'(wb_req), 32'(wbq));
    endtask

    task automatic t_reset();
        check_eq("R1", "chk_done", 32'(chk_done), 0);
        check_eq("R1", "chk_pass", 32'(chk_pass), 0);
        check_eq("R1", "err_code", 32'(err_code), 0);
        check_eq("R1", "proto_err", 32'(proto_err), 0);
        check_eq("R1", "status_word", status_word, 0);
        check_eq("R1", "wb_req", 32'(wb_req), 0);
        check_eq("R1", "wb_word", wb_word, 0);
    endtask

    task automatic t_plain_pass();
        // R3: checksum disabled, word 15 wrong but ignored; R8 write-back requested
        fill(32'h0008_03A5, 32'h1234_5678, 1'b0);
        send_all(0);
        expect_verdict("R3", 1'b1, 2'd0, 1'b1);
        check_eq("R7", "status_word", status_word, exp_status(dw[0], dw[5]));
        check_eq("R8", "wb_word", wb_word, 32'h9234_5678);
    endtask

    task automatic t_sum_pass();
        fill(32'h0024_08A5, 32'h0000_0042, 1'b1);
        send_all(0);
        expect_verdict("R3", 1'b1, 2'd0, 1'b0);
        check_eq("R7", "status_word", status_word, exp_status(dw[0], dw[5]));
    endtask

    task automatic t_bad_key();
        fill(32'h0000_02A4, 32'h0, 1'b1);
        send_all(0);
        expect_verdict("R2", 1'b0, 2'd1, 1'b0);
    endtask

    task automatic t_bad_sum();
        fill(32'h0010_02A5, 32'h0, 1'b0);
        send_all(0);
        expect_verdict("R3", 1'b0, 2'd2, 1'b0);
    endtask

    task automatic t_redone();
        fill(32'h0000_02A5, 32'h8000_0001, 1'b1);
        send_all(0);
        expect_verdict("R4", 1'b0, 2'd3, 1'b0);
        fill(32'h0000_06A5, 32'h8000_0001, 1'b1);
        send_all(0);
        expect_verdict("R4", 1'b1, 2'd0, 1'b1);
        check_eq("R7", "status done bit", status_word, exp_status(dw[0], dw[5]));
    endtask

    task automatic t_priority();
        fill(32'h0010_005A, 32'h8000_0000, 1'b0);
        send_all(0);
        expect_verdict("R5", 1'b0, 2'd1, 1'b0);
        fill(32'h0010_00A5, 32'h8000_0000, 1'b0);
        send_all(0);
        expect_verdict("R5", 1'b0, 2'd2, 1'b0);
    endtask

    task automatic t_pulse_hold();
        fill(32'h0000_03A5, 32'h0000_0007, 1'b1);
        send_all(0);
        expect_verdict("R6", 1'b1, 2'd0, 1'b1);
        idle(); idle(); idle();
        check_eq("R6", "chk_done after pulse", 32'(chk_done), 0);
        check_eq("R6", "chk_pass held", 32'(chk_pass), 1);
        check_eq("R6", "wb_word held", wb_word, 32'h8000_0007);
        put_word(4'd0, 32'h0000_00A5);
        idle();
        check_eq("R6", "chk_pass cleared", 32'(chk_pass), 0);
        check_eq("R6", "status cleared", status_word, 0);
        check_eq("R6", "wb_req cleared", 32'(wb_req), 0);
    endtask

    task automatic t_order();
        fill(32'h0000_00A5, 32'h0, 1'b1);
        for (int i = 0; i < 4; i++) put_word(4'(i), dw[i]);
        idle();
        check_eq("R9", "proto_err in order", 32'(proto_err), 0);
        put_word(4'd5, dw[5]);
        idle();
        check_eq("R9", "proto_err on skip", 32'(proto_err), 1);
        for (int i = 6; i < 16; i++) put_word(4'(i), dw[i]);
        idle();
        check_eq("R9", "no chk_done", 32'(chk_done), 0);
        check_eq("R9", "proto_err held", 32'(proto_err), 1);
        put_word(4'd0, dw[0]);
        idle();
        check_eq("R9", "proto_err cleared", 32'(proto_err), 0);
    endtask

    task automatic t_restart();
        // partial descriptor with a bad preamble, then a full valid one
        fill(32'h0010_0011, 32'h8000_0000, 1'b0);
        for (int i = 0; i < 8; i++) put_word(4'(i), dw[i]);
        fill(32'h0010_00A5, 32'h0000_0003, 1'b1);
        send_all(0);
        expect_verdict("R9", 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_gaps();
        fill(32'h0030_03A5, 32'h0000_0009, 1'b1);
        send_all(2);
        // the verdict is one cycle old after the gap idles; it is still held
        check_eq("R10", "chk_pass", 32'(chk_pass), 1);
        check_eq("R10", "err_code", 32'(err_code), 0);
        check_eq("R10", "status_word", status_word, exp_status(dw[0], dw[5]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_pass();
        t_sum_pass();
        t_bad_key();
        t_bad_sum();
        t_redone();
        t_priority();
        t_pulse_hold();
        t_order();
        t_restart();
        t_gaps();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule